// File: doc/BRIEF.md
# Masked Alarm Match Interrupt Unit

This unit watches a running time-of-day value made of four fields (seconds, minutes, hours, day of week) and compares it against two independently programmed alarms. The comparison happens only on the cycle where the timekeeper announces a clock update. Every alarm byte carries a "don't care" bit in its top position, so one alarm can fire once a week, once a day, once an hour, once a minute or every second, depending on which fields are masked.

A hit latches a sticky request flag for that alarm. A small control register holds one enable bit per alarm and a routing bit that either gives each alarm its own active-low interrupt line or merges both onto the first line. The host never writes a flag to clear it. Instead, any access (read or write) whose address falls on one of an alarm's four registers clears that alarm's flag. If a set and a clear fall in the same cycle, the set wins.

The host reaches the unit through a single-cycle access port. A write to an alarm address loads that alarm byte, and a write to the control address loads the enables and the routing bit. Every access, read or write, counts as a touch for flag clearing.

Top module: `alarm_irq_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, both flags read 0 and both interrupt outputs are high. Reset clears every alarm byte and the control register.
- R2: On a clock-update cycle, when all four mask bits of an alarm are 0 and all four fields equal the current time, that alarm's flag reads 1 after the next clock edge. If any single field differs, the flag stays 0.
- R3: Bit 7 of an alarm byte, when set, makes that field match any value. With day masked the alarm fires daily. With day and hours masked it fires hourly. With day, hours and minutes masked it fires every minute. With all four masked it fires on every update. Bits 6:0 of the byte hold the compared value.
- R4: Without the update strobe, a matching time does not set a flag.
- R5: A set flag stays set on later updates whose time does not match.
- R6: Control register bit 2 is the routing bit. When it is 1, flag 0 gated by enable bit 0 drives `irq0_n` low, and flag 1 gated by enable bit 1 drives `irq1_n` low.
- R7: When the routing bit is 0, either gated flag drives `irq0_n` low and `irq1_n` stays high.
- R8: A flag whose enable bit is 0 leaves its interrupt output high, and the flag itself still reads 1.
- R9: An access, read or write, to addresses 0 to 3 (alarm 0: seconds, minutes, hours, day) clears flag 0 only. An access to addresses 4 to 7 (the same order for alarm 1) clears flag 1 only.
- R10: When a set and a clear of the same flag fall in the same cycle, the flag reads 1 afterwards.
- R11: An access to the control address 8, or to the unmapped addresses 9 to 15, clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock-update strobe, one cycle per time update |
| cur_sec | input | 7 | Current seconds value |
| cur_min | input | 7 | Current minutes value |
| cur_hour | input | 7 | Current hours value |
| cur_dow | input | 7 | Current day-of-week value |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | Access is a write when 1 |
| acc_addr | input | 4 | Access address: 0-3 alarm 0, 4-7 alarm 1, 8 control |
| acc_wdata | input | 8 | Write data |
| alarm_flag | output | 2 | Sticky request flags; bit k belongs to alarm k |
| irq0_n | output | 1 | Active-low interrupt line 0 |
| irq1_n | output | 1 | Active-low interrupt line 1 |

## Verification
A corrupted alarm byte or a wrong mask decode shows up on the flag and on its interrupt line one clock edge after the update strobe that should or should not have hit. A lost or stray flag stays visible until the next access to that alarm, because the flag is sticky. A misdecoded address shows as a flag that survives, or is dropped by, an access on the very next cycle. A wrong routing or enable state shows on the interrupt pins in the same cycle the flag is set, with no extra delay.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    parameter int FIELD_W    = 7;
    parameter int NUM_FIELDS = 4;
    parameter int NUM_ALARMS = 2;
    parameter int ADDR_W     = 4;

    localparam int BYTE_W    = FIELD_W + 1;
    localparam int IDX_W     = $clog2(NUM_FIELDS);
    localparam int TIME_W    = FIELD_W * NUM_FIELDS;
    localparam int CTRL_ADDR = NUM_ALARMS * NUM_FIELDS;

    typedef enum logic [IDX_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DOW  = 2'd3
    } field_e;

    typedef struct packed {
        logic                  route;
        logic [NUM_ALARMS-1:0] en;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } access_t;

    function automatic logic field_hit(input logic [BYTE_W-1:0] alm,
                                       input logic [FIELD_W-1:0] cur);
        return alm[BYTE_W-1] | (alm[FIELD_W-1:0] == cur);
    endfunction

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_irq_pkg::*;
(
    input  logic [BYTE_W-1:0]  alm_byte,
    input  logic [FIELD_W-1:0] cur_field,
    output logic               hit
);
    always_comb hit = field_hit(alm_byte, cur_field);
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              touch,
    output logic              flag
);
    logic [BYTE_W-1:0]     alm_q [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hits;
    logic                  match;
    logic                  flag_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                alm_q[i] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                alm_q[i] <= wdata;
        end

        alarm_field_cmp u_cmp (
            .alm_byte  (alm_q[i]),
            .cur_field (cur_time[i*FIELD_W +: FIELD_W]),
            .hit       (hits[i])
        );
    end

    always_comb match = &hits;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (tick && match)
            flag_q <= 1'b1;
        else if (touch)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
    import alarm_irq_pkg::*;
(
    input  logic [NUM_ALARMS-1:0] flags,
    input  ctrl_t                 ctrl,
    output logic                  irq0_n,
    output logic                  irq1_n
);
    logic [NUM_ALARMS-1:0] gated;

    always_comb begin
        gated = flags & ctrl.en;
        if (ctrl.route) begin
            irq0_n = ~gated[0];
            irq1_n = ~gated[1];
        end else begin
            irq0_n = ~(|gated);
            irq1_n = 1'b1;
        end
    end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [FIELD_W-1:0]    cur_sec,
    input  logic [FIELD_W-1:0]    cur_min,
    input  logic [FIELD_W-1:0]    cur_hour,
    input  logic [FIELD_W-1:0]    cur_dow,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [BYTE_W-1:0]     acc_wdata,
    output logic [NUM_ALARMS-1:0] alarm_flag,
    output logic                  irq0_n,
    output logic                  irq1_n
);
    access_t           acc;
    ctrl_t             ctrl_q;
    logic [TIME_W-1:0] cur_time;

    always_comb begin
        acc.valid = acc_valid;
        acc.write = acc_write;
        acc.addr  = acc_addr;
        acc.wdata = acc_wdata;
        cur_time  = '0;
        cur_time[FLD_SEC  * FIELD_W +: FIELD_W] = cur_sec;
        cur_time[FLD_MIN  * FIELD_W +: FIELD_W] = cur_min;
        cur_time[FLD_HOUR * FIELD_W +: FIELD_W] = cur_hour;
        cur_time[FLD_DOW  * FIELD_W +: FIELD_W] = cur_dow;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (acc.valid && acc.write && (acc.addr == ADDR_W'(CTRL_ADDR)))
            ctrl_q <= ctrl_t'(acc.wdata[$bits(ctrl_t)-1:0]);
    end

    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
        logic sel;
        always_comb sel = acc.valid &&
                          (acc.addr[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'(k));

        alarm_channel u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cur_time (cur_time),
            .wr_en    (sel && acc.write),
            .wr_idx   (acc.addr[IDX_W-1:0]),
            .wdata    (acc.wdata),
            .touch    (sel),
            .flag     (alarm_flag[k])
        );
    end

    alarm_irq_router u_router (
        .flags  (alarm_flag),
        .ctrl   (ctrl_q),
        .irq0_n (irq0_n),
        .irq1_n (irq1_n)
    );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
    import alarm_irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  acc_valid,
    input logic [ADDR_W-1:0]     acc_addr,
    input logic [NUM_ALARMS-1:0] alarm_flag,
    input logic                  irq0_n,
    input logic                  irq1_n,
    input logic [NUM_ALARMS-1:0] ctrl_en,
    input logic                  ctrl_route
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (alarm_flag == '0));

    p_set_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag[0]) |-> $past(tick));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag[0] && !(acc_valid && acc_addr < ADDR_W'(4))) |=> alarm_flag[0]);

    p_irq1_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_route |-> irq1_n);

    p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en == '0) |-> (irq0_n && irq1_n));

    p_touch0_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr < ADDR_W'(4) && !tick) |=> !alarm_flag[0]);

    p_touch1_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr >= ADDR_W'(4) && acc_addr < ADDR_W'(8) && !tick)
        |=> !alarm_flag[1]);
endmodule

bind alarm_irq_unit alarm_irq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .alarm_flag (alarm_flag),
    .irq0_n     (irq0_n),
    .irq1_n     (irq1_n),
    .ctrl_en    (ctrl_q.en),
    .ctrl_route (ctrl_q.route)
);

// File: tb/test_alarm_irq_unit.sv
module test_alarm_irq_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_dow = '0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [1:0] alarm_flag;
    logic       irq0_n, irq1_n;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alarm_irq_unit i_alarm_irq_unit (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .alarm_flag(alarm_flag), .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    // {a_sec,a_min,a_hour,a_day (8 each), t_sec,t_min,t_hour,t_dow (7 each), expect}
    localparam int NVEC = 9;
    localparam logic [60:0] VEC [NVEC] = '{
        {8'h30, 8'h15, 8'h08, 8'h03, 7'h30, 7'h15, 7'h08, 7'h03, 1'b1}, // R2 full match
        {8'h30, 8'h15, 8'h08, 8'h03, 7'h31, 7'h15, 7'h08, 7'h03, 1'b0}, // R2 sec differs
        {8'h30, 8'h15, 8'h08, 8'h03, 7'h30, 7'h15, 7'h08, 7'h04, 1'b0}, // R2 day differs
        {8'h30, 8'h15, 8'h08, 8'h83, 7'h30, 7'h15, 7'h08, 7'h06, 1'b1}, // R3 daily
        {8'h30, 8'h15, 8'h88, 8'h83, 7'h30, 7'h15, 7'h11, 7'h01, 1'b1}, // R3 hourly
        {8'h30, 8'h15, 8'h88, 8'h83, 7'h30, 7'h16, 7'h11, 7'h01, 1'b0}, // R3 hourly miss
        {8'h30, 8'h95, 8'h88, 8'h83, 7'h30, 7'h42, 7'h23, 7'h05, 1'b1}, // R3 each minute
        {8'hB0, 8'h95, 8'h88, 8'h83, 7'h07, 7'h42, 7'h23, 7'h05, 1'b1}, // R3 each second
        {8'h59, 8'h00, 8'h12, 8'h02, 7'h59, 7'h00, 7'h13, 7'h02, 1'b0}  // R2 hour differs
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, m, h, d);
        cur_sec = s; cur_min = m; cur_hour = h; cur_dow = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(alarm_flag == 2'b00 && irq0_n && irq1_n, "R1 in reset",
              {alarm_flag, irq0_n, irq1_n}, 4'b0011);
        rst = 1'b0;
        @(negedge clk);
        check(alarm_flag == 2'b00 && irq0_n && irq1_n, "R1 after reset",
              {alarm_flag, irq0_n, irq1_n}, 4'b0011);

        access(1, 4'd8, 8'h05); // route=1, en0=1
        for (int v = 0; v < NVEC; v++) begin
            access(1, 4'd0, VEC[v][60:53]);
            access(1, 4'd1, VEC[v][52:45]);
            access(1, 4'd2, VEC[v][44:37]);
            access(1, 4'd3, VEC[v][36:29]);
            set_time(VEC[v][28:22], VEC[v][21:15], VEC[v][14:8], VEC[v][7:1]);
            pulse_tick();
            check(alarm_flag[0] == VEC[v][0], "R2/R3 vector flag", alarm_flag[0], VEC[v][0]);
            check(irq0_n == !VEC[v][0], "R6 vector irq0", irq0_n, !VEC[v][0]);
        end

        // R4: exact match on alarm 0 but no strobe
        access(1, 4'd0, 8'h10); access(1, 4'd1, 8'h20);
        access(1, 4'd2, 8'h05); access(1, 4'd3, 8'h02);
        set_time(7'h10, 7'h20, 7'h05, 7'h02);
        repeat (3) @(negedge clk);
        check(alarm_flag[0] == 1'b0, "R4 no tick", alarm_flag[0], 0);

        // R5: set, then mismatching update keeps it
        pulse_tick();
        check(alarm_flag[0] == 1'b1, "R5 set", alarm_flag[0], 1);
        set_time(7'h11, 7'h20, 7'h05, 7'h02);
        pulse_tick();
        check(alarm_flag[0] == 1'b1, "R5 sticky", alarm_flag[0], 1);

        // R11: control and unmapped accesses clear nothing
        access(0, 4'd8, 8'h00);
        check(alarm_flag[0] == 1'b1, "R11 ctrl read", alarm_flag[0], 1);
        access(1, 4'd12, 8'hFF);
        check(alarm_flag[0] == 1'b1, "R11 unmapped write", alarm_flag[0], 1);

        // R9: alarm 1 access leaves flag 0, alarm 0 read clears it
        access(0, 4'd5, 8'h00);
        check(alarm_flag[0] == 1'b1, "R9 other alarm", alarm_flag[0], 1);
        access(0, 4'd2, 8'h00);
        check(alarm_flag[0] == 1'b0, "R9 read clears 0", alarm_flag[0], 0);

        // Alarm 1 every update; alarm 0 never (mismatch on day)
        access(1, 4'd3, 8'h07);
        access(1, 4'd4, 8'h80); access(1, 4'd5, 8'h80);
        access(1, 4'd6, 8'h80); access(1, 4'd7, 8'h80);
        access(1, 4'd8, 8'h06); // route=1, en1=1
        pulse_tick();
        check(alarm_flag == 2'b10, "R3 alarm1 every update", alarm_flag, 2'b10);
        check(irq1_n == 1'b0 && irq0_n == 1'b1, "R6 irq1 separate",
              {irq0_n, irq1_n}, 2'b10);

        access(1, 4'd8, 8'h02); // route=0, en1=1
        check(irq0_n == 1'b0 && irq1_n == 1'b1, "R7 shared line",
              {irq0_n, irq1_n}, 2'b01);

        access(1, 4'd8, 8'h04); // route=1, enables off
        check(irq0_n && irq1_n && alarm_flag[1], "R8 gated off",
              {irq0_n, irq1_n, alarm_flag[1]}, 3'b111);

        access(1, 4'd7, 8'h80);
        check(alarm_flag[1] == 1'b0, "R9 write clears 1", alarm_flag[1], 0);

        // R10: update hit and touch of alarm 1 in the same cycle
        @(negedge clk);
        tick = 1'b1; acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 4'd6;
        @(negedge clk);
        tick = 1'b0; acc_valid = 1'b0;
        check(alarm_flag[1] == 1'b1, "R10 set wins", alarm_flag[1], 1);

        // R1: reset mid-run clears flags
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(alarm_flag == 2'b00 && irq0_n && irq1_n, "R1 re-reset",
              {alarm_flag, irq0_n, irq1_n}, 4'b0011);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule